// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits behind the command bus of a parallel NOR flash. Every rising edge of the write strobe is one bus cycle. The block reads those cycles as command sequences: single program, multi-cycle buffered write, block erase, block lock-bit set, master lock-bit set and clear-all-locks. It keeps the per-block lock bits, the master lock bit and a status byte. It hands program, buffered-write and erase work to the array side through a request/done handshake.

Accepted array operations give one request pulse, with the operation code, target address, data and buffer length held steady. A buffered write first fills a small on-chip buffer. The array side reads that buffer through an index port with one cycle of read latency. Lock changes happen inside the block, gated by the master lock bit and by a flag that reports a high-voltage level on the reset pin.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte reads 80h (bit 7 = ready, every error bit clear), all block lock bits and the master lock bit are 0, and no request is issued.
- R2: A write of 40h or 10h in the low byte starts a program sequence. The next write issues a request with arr_op = 1, arr_addr equal to that write's address, and arr_data equal to its data (the low byte zero-extended in byte mode).
- R3: In word mode the upper data byte is ignored when a command code is decoded, so AB40h starts a program and 77D0h confirms an erase.
- R4: A write of E8h followed by a count N and exactly N+1 data writes, then D0h, issues one request with arr_op = 2, arr_len = N and arr_addr equal to the address of the count cycle. No request occurs before the D0h. Data cycle k is stored at buffer index k and appears on arr_buf_rdata one cycle after arr_buf_idx = k.
- R5: A count above 1Fh in byte mode or above 000Fh in word mode ends the sequence with status bits 5 and 4 set and no request. 1Fh in byte mode is accepted.
- R6: Any code other than D0h in the cycle after the N+1 data writes aborts the buffered write. It sets status bits 5 and 4 and issues no request.
- R7: 20h followed by D0h issues an erase request (arr_op = 3) for the addressed block. 20h followed by another code sets bits 5 and 4 and issues no request.
- R8: A program, buffered write or erase to a locked block while hv_reset is low is refused with no request. Program and buffer refusals set bit 4, erase refusals set bit 5, and both also set bit 1. With hv_reset high the operation proceeds.
- R9: 60h then 01h sets the lock bit of the addressed block (block = top 6 address bits). This works without hv_reset while the master bit is clear. Once the master bit is set, it needs hv_reset, and without it bit 4 is set and the lock is unchanged.
- R10: 60h then F1h sets the master lock bit only with hv_reset high. Otherwise bit 4 is set and the master bit stays 0.
- R11: 60h then D0h clears every block lock bit in one step. When the master bit is set this needs hv_reset, and without it bit 5 is set and the locks are unchanged.
- R12: A code outside the supported set (40h, 10h, E8h, 20h, 60h, 50h, FFh, 70h, 90h, 98h) sets bits 5 and 4 and leaves the sequencer idle.
- R13: Each accepted array operation gives exactly one request pulse. Ready (bit 7) is 0 from that pulse until arr_done, and strobe writes made while not ready are ignored.
- R14: Error bits 5, 4 and 1 stay set across later commands until a write of 50h clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Bus write strobe; a rising edge is one command cycle |
| wr_addr | input | ADDR_W | Bus address |
| wr_data | input | 16 | Bus data |
| word_mode | input | 1 | 1 = x16 bus, 0 = x8 bus |
| hv_reset | input | 1 | Reset pin is at high voltage |
| status_o | output | 8 | Status byte |
| lock_o | output | NBLK | Block lock bits |
| master_lock_o | output | 1 | Master lock bit |
| arr_req | output | 1 | One-cycle operation request |
| arr_op | output | 2 | 1 program, 2 buffered write, 3 erase |
| arr_addr | output | ADDR_W | Operation address |
| arr_data | output | 16 | Program data |
| arr_len | output | IDX_W | Buffer count N |
| arr_buf_idx | input | IDX_W | Buffer read index |
| arr_buf_rdata | output | 16 | Buffer read data, one cycle after index |
| arr_done | input | 1 | Array finished current operation |

## Verification
The hardest state to reach is the master-locked case. Clearing or adding block locks must then be refused without the high-voltage flag and allowed with it. The stimulus first sets block locks freely and proves the clear-all path while the master bit is still clear. It then sets the master bit under the flag and repeats the lock commands with the flag low and high. A second hard case is a write arriving while an operation runs. The bench holds back arr_done, issues a program setup during the busy window, and after completion sends a code that would be program data if the setup had been taken but is reserved otherwise.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_BUF   = 2'd2,
    OP_ERASE = 2'd3
  } arr_op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PGM, S_BCNT, S_BDAT, S_BCONF, S_ECONF, S_LCONF, S_BUSY
  } seq_state_t;

  localparam logic [7:0] C_PROG_A   = 8'h40;
  localparam logic [7:0] C_PROG_B   = 8'h10;
  localparam logic [7:0] C_BUFWR    = 8'hE8;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_LOCKSET  = 8'h60;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_BLKLOCK  = 8'h01;
  localparam logic [7:0] C_MASTER   = 8'hF1;
  localparam logic [7:0] C_CLRSTAT  = 8'h50;
  localparam logic [7:0] C_RDARRAY  = 8'hFF;
  localparam logic [7:0] C_RDSTAT   = 8'h70;
  localparam logic [7:0] C_RDID     = 8'h90;
  localparam logic [7:0] C_QUERY    = 8'h98;

  localparam int SB_READY = 7;
  localparam int SB_ERASE = 5;
  localparam int SB_PROG  = 4;
  localparam int SB_LOCK  = 1;
endpackage

// File: rtl/fcs_strobe_capture.sv
module fcs_strobe_capture #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              evt,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q   <= 1'b0;
      evt     <= 1'b0;
      ev_addr <= '0;
      ev_data <= '0;
    end else begin
      stb_q <= wr_stb;
      evt   <= wr_stb & ~stb_q;
      if (wr_stb && !stb_q) begin
        ev_addr <= wr_addr;
        ev_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fcs_wbuf.sv
module fcs_wbuf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcs_lock_bank.sv
module fcs_lock_bank #(
  parameter int NBLK  = 64,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic             mset,
  output logic [NBLK-1:0]  locks,
  output logic             master
);
  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                 locks[b] <= 1'b0;
      else if (clr_all)                        locks[b] <= 1'b0;
      else if (set_en && set_idx == BLK_W'(b)) locks[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       master <= 1'b0;
    else if (mset) master <= 1'b1;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int NBLK      = 64,
  parameter int BUF_WORDS = 16,
  localparam int BLK_W    = $clog2(NBLK),
  localparam int IDX_W    = $clog2(2 * BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              word_mode,
  input  logic              hv_reset,
  output logic [7:0]        status_o,
  output logic [NBLK-1:0]   lock_o,
  output logic              master_lock_o,
  output logic              arr_req,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [15:0]       arr_data,
  output logic [IDX_W-1:0]  arr_len,
  input  logic [IDX_W-1:0]  arr_buf_idx,
  output logic [15:0]       arr_buf_rdata,
  input  logic              arr_done
);
  localparam logic [15:0] MAX_WORD = 16'(BUF_WORDS - 1);
  localparam logic [15:0] MAX_BYTE = 16'(2 * BUF_WORDS - 1);

  logic              evt;
  logic [ADDR_W-1:0] ev_addr;
  logic [15:0]       ev_data;

  fcs_strobe_capture #(.ADDR_W(ADDR_W), .DATA_W(16)) u_cap (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt(evt), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  seq_state_t        state;
  logic [IDX_W-1:0]  idx, len_q;
  logic [ADDR_W-1:0] base_q;
  logic              err_e, err_p, err_lk;
  logic              req_q;
  arr_op_t           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;

  // command decode and data shaping
  logic [7:0]  cmd;
  logic [15:0] bus_val;
  logic [15:0] cnt_max;
  logic [BLK_W-1:0] ev_blk, base_blk;
  logic        ev_locked, base_locked, lk_ok;
  logic        lk_set, lk_clr, lk_mset, buf_we;

  assign cmd      = ev_data[7:0];
  assign bus_val  = word_mode ? ev_data : {8'h00, ev_data[7:0]};
  assign cnt_max  = word_mode ? MAX_WORD : MAX_BYTE;
  assign ev_blk   = ev_addr[ADDR_W-1 -: BLK_W];
  assign base_blk = base_q[ADDR_W-1 -: BLK_W];
  assign ev_locked   = lock_o[ev_blk] & ~hv_reset;
  assign base_locked = lock_o[base_blk] & ~hv_reset;
  assign lk_ok    = ~master_lock_o | hv_reset;
  assign buf_we   = evt && (state == S_BDAT);

  always_comb begin
    lk_set  = 1'b0;
    lk_clr  = 1'b0;
    lk_mset = 1'b0;
    if (evt && state == S_LCONF) begin
      case (cmd)
        C_BLKLOCK: lk_set  = lk_ok;
        C_MASTER:  lk_mset = hv_reset;
        C_CONFIRM: lk_clr  = lk_ok;
        default: ;
      endcase
    end
  end

  fcs_lock_bank #(.NBLK(NBLK)) u_locks (
    .clk(clk), .rst(rst), .set_en(lk_set), .set_idx(ev_blk),
    .clr_all(lk_clr), .mset(lk_mset), .locks(lock_o), .master(master_lock_o)
  );

  fcs_wbuf #(.DEPTH(2 * BUF_WORDS), .DATA_W(16)) u_buf (
    .clk(clk), .we(buf_we), .waddr(idx), .wdata(bus_val),
    .raddr(arr_buf_idx), .rdata(arr_buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx    <= '0;
      len_q  <= '0;
      base_q <= '0;
      err_e  <= 1'b0;
      err_p  <= 1'b0;
      err_lk <= 1'b0;
      req_q  <= 1'b0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q <= 1'b0;
      case (state)
        S_IDLE: if (evt) begin
          case (cmd)
            C_PROG_A, C_PROG_B: state <= S_PGM;
            C_BUFWR:            state <= S_BCNT;
            C_ERASE:            state <= S_ECONF;
            C_LOCKSET:          state <= S_LCONF;
            C_CLRSTAT: begin
              err_e  <= 1'b0;
              err_p  <= 1'b0;
              err_lk <= 1'b0;
            end
            C_RDARRAY, C_RDSTAT, C_RDID, C_QUERY: ;
            default: begin
              err_e <= 1'b1;
              err_p <= 1'b1;
            end
          endcase
        end
        S_PGM: if (evt) begin
          if (ev_locked) begin
            err_p  <= 1'b1;
            err_lk <= 1'b1;
            state  <= S_IDLE;
          end else begin
            req_q  <= 1'b1;
            op_q   <= OP_PROG;
            addr_q <= ev_addr;
            data_q <= bus_val;
            state  <= S_BUSY;
          end
        end
        S_BCNT: if (evt) begin
          if ((word_mode ? ev_data : bus_val) > cnt_max) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else begin
            len_q  <= bus_val[IDX_W-1:0];
            base_q <= ev_addr;
            idx    <= '0;
            state  <= S_BDAT;
          end
        end
        S_BDAT: if (evt) begin
          idx <= idx + 1'b1;
          if (idx == len_q) state <= S_BCONF;
        end
        S_BCONF: if (evt) begin
          if (cmd != C_CONFIRM) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else if (base_locked) begin
            err_p  <= 1'b1;
            err_lk <= 1'b1;
            state  <= S_IDLE;
          end else begin
            req_q  <= 1'b1;
            op_q   <= OP_BUF;
            addr_q <= base_q;
            state  <= S_BUSY;
          end
        end
        S_ECONF: if (evt) begin
          if (cmd != C_CONFIRM) begin
            err_e <= 1'b1;
            err_p <= 1'b1;
            state <= S_IDLE;
          end else if (ev_locked) begin
            err_e  <= 1'b1;
            err_lk <= 1'b1;
            state  <= S_IDLE;
          end else begin
            req_q  <= 1'b1;
            op_q   <= OP_ERASE;
            addr_q <= ev_addr;
            state  <= S_BUSY;
          end
        end
        S_LCONF: if (evt) begin
          case (cmd)
            C_BLKLOCK: if (!lk_ok)    err_p <= 1'b1;
            C_MASTER:  if (!hv_reset) err_p <= 1'b1;
            C_CONFIRM: if (!lk_ok)    err_e <= 1'b1;
            default: begin
              err_e <= 1'b1;
              err_p <= 1'b1;
            end
          endcase
          state <= S_IDLE;
        end
        S_BUSY: if (arr_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign arr_req  = req_q;
  assign arr_op   = op_q;
  assign arr_addr = addr_q;
  assign arr_data = data_q;
  assign arr_len  = len_q;
  assign status_o = {(state != S_BUSY), 1'b0, err_e, err_p, 2'b00, err_lk, 1'b0};
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W = 23,
  parameter int NBLK   = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              hv_reset,
  input logic              arr_req,
  input logic              arr_done,
  input logic [1:0]        arr_op,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [7:0]        status_o,
  input logic [NBLK-1:0]   lock_o,
  input logic              master_lock_o
);
  // R13: request is a single-cycle pulse
  p_req_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    arr_req |=> !arr_req);

  // R13: ready low while a request is outstanding
  p_req_busy_r13: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> !status_o[7]);

  // R13: done returns the sequencer to ready
  p_done_ready_r13: assert property (@(posedge clk) disable iff (rst)
    (arr_done && !status_o[7]) |=> status_o[7]);

  // R13: operation fields hold while busy
  p_fields_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!status_o[7] && !arr_req) |-> ($stable(arr_op) && $stable(arr_addr)));

  // R10: master bit only rises with the high-voltage flag
  p_master_hv_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(master_lock_o) |-> $past(hv_reset));

  // R10: master bit never falls
  p_master_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$fell(master_lock_o));

  // R9: new block locks under a set master bit need the flag
  p_lockset_hv_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(master_lock_o) && ((lock_o & ~$past(lock_o)) != '0)) |-> $past(hv_reset));

  // R11: locks drop only all together
  p_clear_all_r11: assert property (@(posedge clk) disable iff (rst)
    ((~lock_o & $past(lock_o)) != '0) |-> (lock_o == '0));
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst(rst), .hv_reset(hv_reset), .arr_req(arr_req),
  .arr_done(arr_done), .arr_op(arr_op), .arr_addr(arr_addr),
  .status_o(status_o), .lock_o(lock_o), .master_lock_o(master_lock_o)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 23;
  localparam int NBLK   = 64;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_stb = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic              word_mode = 1'b1;
  logic              hv_reset = 1'b0;
  logic [7:0]        status_o;
  logic [NBLK-1:0]   lock_o;
  logic              master_lock_o;
  logic              arr_req;
  logic [1:0]        arr_op;
  logic [ADDR_W-1:0] arr_addr;
  logic [15:0]       arr_data;
  logic [IDX_W-1:0]  arr_len;
  logic [IDX_W-1:0]  arr_buf_idx = '0;
  logic [15:0]       arr_buf_rdata;
  logic              arr_done = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int req_count = 0;
  int done_delay = 2;
  int dcnt = 0;
  logic [1:0]        last_op;
  logic [ADDR_W-1:0] last_addr;
  logic [15:0]       last_data;
  logic [IDX_W-1:0]  last_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .NBLK(NBLK), .BUF_WORDS(16)) u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_mode(word_mode), .hv_reset(hv_reset), .status_o(status_o),
    .lock_o(lock_o), .master_lock_o(master_lock_o), .arr_req(arr_req),
    .arr_op(arr_op), .arr_addr(arr_addr), .arr_data(arr_data), .arr_len(arr_len),
    .arr_buf_idx(arr_buf_idx), .arr_buf_rdata(arr_buf_rdata), .arr_done(arr_done)
  );

  // array-side responder
  always @(negedge clk) begin
    arr_done = 1'b0;
    if (!rst) begin
      if (arr_req) begin
        req_count++;
        last_op   = arr_op;
        last_addr = arr_addr;
        last_data = arr_data;
        last_len  = arr_len;
        dcnt      = done_delay;
      end else if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) arr_done = 1'b1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200; i++) begin
      if (status_o[7] && dcnt == 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] blk(input int b, input int off);
    return ADDR_W'(b << (ADDR_W - 6)) | ADDR_W'(off);
  endfunction

  task automatic clear_status();
    bus_write('0, 16'h0050);
    check("R14 clear", status_o, 8'h80);
  endtask

  task automatic t_reset();
    check("R1 status", status_o, 8'h80);
    check("R1 locks", lock_o == '0, 1);
    check("R1 master", master_lock_o, 0);
    check("R1 no req", req_count, 0);
  endtask

  task automatic t_program();
    int c0 = req_count;
    word_mode = 1'b1;
    bus_write('0, 16'h0040);
    bus_write(blk(1, 16'h0123), 16'hBEEF);
    wait_ready();
    check("R2 count 40h", req_count, c0 + 1);
    check("R2 op", last_op, 1);
    check("R2 addr", last_addr, blk(1, 16'h0123));
    check("R2 data", last_data, 16'hBEEF);
    check("R13 ready back", status_o, 8'h80);
    word_mode = 1'b0;
    bus_write('0, 16'h0010);
    bus_write(blk(2, 7), 16'h12A5);
    wait_ready();
    check("R2 count 10h", req_count, c0 + 2);
    check("R2 byte data", last_data, 16'h00A5);
    word_mode = 1'b1;
  endtask

  task automatic t_upper();
    int c0 = req_count;
    bus_write('0, 16'hAB40);
    bus_write(blk(3, 4), 16'h5A5A);
    wait_ready();
    check("R3 prog upper", req_count, c0 + 1);
    check("R3 prog op", last_op, 1);
    bus_write(blk(4, 0), 16'h5520);
    bus_write(blk(4, 0), 16'h77D0);
    wait_ready();
    check("R3 erase upper", req_count, c0 + 2);
    check("R7 erase op", last_op, 3);
    check("R7 erase addr", last_addr, blk(4, 0));
    bus_write(blk(4, 0), 16'h0020);
    bus_write(blk(4, 0), 16'h0040);
    check("R7 bad confirm", status_o, 8'hB0);
    check("R7 no req", req_count, c0 + 2);
    clear_status();
  endtask

  task automatic t_buffer();
    int c0 = req_count;
    word_mode = 1'b1;
    bus_write(blk(6, 0), 16'h00E8);
    bus_write(blk(6, 16'h40), 16'h0003);
    bus_write(blk(6, 16'h40), 16'h1111);
    bus_write(blk(6, 16'h41), 16'h2222);
    bus_write(blk(6, 16'h42), 16'h3333);
    bus_write(blk(6, 16'h43), 16'h4444);
    check("R4 no start before confirm", req_count, c0);
    bus_write(blk(6, 0), 16'h00D0);
    wait_ready();
    check("R4 req", req_count, c0 + 1);
    check("R4 op", last_op, 2);
    check("R4 len", last_len, 3);
    check("R4 base", last_addr, blk(6, 16'h40));
    @(negedge clk); arr_buf_idx = 5'd2;
    @(negedge clk);
    check("R4 buf data", arr_buf_rdata, 16'h3333);
    // byte mode maximum count
    word_mode = 1'b0;
    bus_write(blk(6, 0), 16'h00E8);
    bus_write(blk(6, 0), 16'h001F);
    for (int i = 0; i < 32; i++) bus_write(blk(6, i), 16'(16'h0080 + i));
    bus_write(blk(6, 0), 16'h00D0);
    wait_ready();
    check("R5 1Fh accepted", req_count, c0 + 2);
    check("R5 len 31", last_len, 31);
    @(negedge clk); arr_buf_idx = 5'd31;
    @(negedge clk);
    check("R4 last byte", arr_buf_rdata, 16'h009F);
    word_mode = 1'b1;
  endtask

  task automatic t_range_abort();
    int c0 = req_count;
    word_mode = 1'b1;
    bus_write('0, 16'h00E8);
    bus_write('0, 16'h0010);
    check("R5 word over", status_o, 8'hB0);
    clear_status();
    word_mode = 1'b0;
    bus_write('0, 16'h00E8);
    bus_write('0, 16'h0020);
    check("R5 byte over", status_o, 8'hB0);
    clear_status();
    word_mode = 1'b1;
    bus_write('0, 16'h00E8);
    bus_write('0, 16'h0001);
    bus_write('0, 16'h0AAA);
    bus_write('0, 16'h0BBB);
    bus_write('0, 16'h00FF);
    check("R6 abort", status_o, 8'hB0);
    check("R6 no req", req_count, c0);
    clear_status();
  endtask

  task automatic t_reserved();
    bus_write('0, 16'h0033);
    check("R12 reserved", status_o, 8'hB0);
    bus_write('0, 16'h00FF);
    check("R14 sticky", status_o, 8'hB0);
    clear_status();
  endtask

  task automatic t_locks();
    int c0;
    hv_reset = 1'b0;
    bus_write(blk(2, 0), 16'h0060); bus_write(blk(2, 0), 16'h0001);
    bus_write(blk(3, 0), 16'h0060); bus_write(blk(3, 0), 16'h0001);
    check("R9 set free", lock_o[3:2], 2'b11);
    bus_write('0, 16'h0060); bus_write('0, 16'h00D0);
    check("R11 clear all", lock_o == '0, 1);
    bus_write(blk(5, 0), 16'h0060); bus_write(blk(5, 0), 16'h0001);
    check("R9 lock 5", lock_o[5], 1);
    c0 = req_count;
    bus_write('0, 16'h0040); bus_write(blk(5, 9), 16'h1234);
    check("R8 prog locked", status_o, 8'h92);
    clear_status();
    bus_write(blk(5, 0), 16'h0020); bus_write(blk(5, 0), 16'h00D0);
    check("R8 erase locked", status_o, 8'hA2);
    clear_status();
    bus_write(blk(5, 0), 16'h00E8); bus_write(blk(5, 0), 16'h0000);
    bus_write(blk(5, 0), 16'h0101); bus_write(blk(5, 0), 16'h00D0);
    check("R8 buf locked", status_o, 8'h92);
    check("R8 no req", req_count, c0);
    clear_status();
    hv_reset = 1'b1;
    bus_write('0, 16'h0040); bus_write(blk(5, 9), 16'h1234);
    hv_reset = 1'b0;
    wait_ready();
    check("R8 hv allows", req_count, c0 + 1);
  endtask

  task automatic t_master();
    bus_write('0, 16'h0060); bus_write('0, 16'h00F1);
    check("R10 no hv status", status_o, 8'h90);
    check("R10 no hv master", master_lock_o, 0);
    clear_status();
    hv_reset = 1'b1;
    bus_write('0, 16'h0060); bus_write('0, 16'h00F1);
    hv_reset = 1'b0;
    check("R10 master set", master_lock_o, 1);
    bus_write(blk(7, 0), 16'h0060); bus_write(blk(7, 0), 16'h0001);
    check("R9 master blocks", status_o, 8'h90);
    check("R9 lock 7 unchanged", lock_o[7], 0);
    clear_status();
    hv_reset = 1'b1;
    bus_write(blk(7, 0), 16'h0060); bus_write(blk(7, 0), 16'h0001);
    hv_reset = 1'b0;
    check("R9 lock 7 hv", lock_o[7], 1);
    bus_write('0, 16'h0060); bus_write('0, 16'h00D0);
    check("R11 clear refused", status_o, 8'hA0);
    check("R11 locks kept", lock_o[7] & lock_o[5], 1);
    clear_status();
    hv_reset = 1'b1;
    bus_write('0, 16'h0060); bus_write('0, 16'h00D0);
    hv_reset = 1'b0;
    check("R11 clear hv", lock_o == '0, 1);
  endtask

  task automatic t_busy();
    int c0 = req_count;
    done_delay = 40;
    bus_write('0, 16'h0040); bus_write(blk(9, 1), 16'h4321);
    check("R13 ready low", status_o[7], 0);
    bus_write('0, 16'h0040);
    wait_ready();
    done_delay = 2;
    bus_write('0, 16'h1234);
    check("R13 busy write ignored", status_o, 8'hB0);
    check("R13 one pulse", req_count, c0 + 1);
    clear_status();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_program();
    t_upper();
    t_buffer();
    t_range_abort();
    t_reserved();
    t_locks();
    t_master();
    t_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule